// File: doc/BRIEF.md
# Supply Supervisor with Reset Stretch and Watchdog

The block turns a set of digital supply-good flags and an active-low manual reset into one active-low processor reset. The reset is asserted while any monitored supply is flagged bad or the manual reset is pressed. When every condition is good again, the reset either releases at once or is held for a fixed stretch interval, and a select input picks between the two. It also runs a watchdog that the processor restarts with rising edges on a trigger input. If the processor stops sending these edges, the watchdog raises an interrupt.

All external inputs pass through a two-flop synchronizer on the master clock. The timing comes from the master clock alone. A logic tick is formed every `TICK_DIV` master clocks (32 gives 250 kHz from 8 MHz), and a millisecond strobe is formed every `MS_TICKS` logic ticks. All intervals are counted in whole milliseconds, so a test setup can make both prescalers smaller to shorten the time base. The watchdog is cleared and stopped while the processor reset is asserted. The watchdog timeout select is captured only when the watchdog restarts.

Top module: `sup_rst_wdt`

## Requirements
- R1: `cpu_rst_no` is 0 within 6 master clocks after `mr_ni` goes low, and stays 0 while it is low.
- R2: With `stretch_sel_i` = 0, `cpu_rst_no` returns to 1 within 6 master clocks after all rail flags are 1 and `mr_ni` is 1.
- R3: With `stretch_sel_i` = 1, `cpu_rst_no` stays 0 for `STRETCH_MS` ms (one ms strobe of tolerance) after all conditions become good, and then goes to 1. A fault during the stretch restarts the interval from zero.
- R4: Each bit of `rail_ok_i` on its own forces `cpu_rst_no` to 0 within 6 master clocks when it is 0.
- R5: The watchdog timeout select code maps 2'b00 to `WDT_MS_0` (500 ms), 2'b01 to `WDT_MS_1` (2 s), 2'b10 to `WDT_MS_2` (10 s) and 2'b11 to `WDT_MS_3` (60 s). `wdt_irq_o` rises once that time has passed since the last restart, within one ms strobe of tolerance.
- R6: Only a rising edge of `wdt_kick_i` restarts the watchdog and clears `wdt_irq_o`. A level held high, or a falling edge, has no effect.
- R7: Once `wdt_irq_o` is set, it stays at 1 until the next trigger edge or until the processor reset is asserted.
- R8: While `cpu_rst_no` is 0, `wdt_irq_o` is 0 and the watchdog does not count. Counting starts from zero when the reset releases.
- R9: A change of `wdt_sel_i` has no effect on the running interval. It applies from the next restart, which is either a trigger edge or a reset release.
- R10: While `rst_ni` is 0, `cpu_rst_no` is 0 and `wdt_irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, nominally 8 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rail_ok_i | input | N_RAILS | Supply-good flags, 1 = rail in range |
| mr_ni | input | 1 | Manual reset, active low |
| wdt_kick_i | input | 1 | Watchdog trigger, acts on its rising edge |
| stretch_sel_i | input | 1 | 1 = hold the reset for STRETCH_MS after recovery |
| wdt_sel_i | input | 2 | Watchdog timeout code |
| cpu_rst_no | output | 1 | Processor reset, active low |
| wdt_irq_o | output | 1 | Watchdog expiry interrupt, sticky |

## Verification
The reset path is first driven by each rail flag on its own and then by the manual reset, which shows that every fault source is decoded separately. Recovery is tested once with the stretch off, where release must be immediate, and once with the stretch on. In the stretched case a fault is also injected partway through the stretch, which separates an interval that restarts from one that only pauses. On the watchdog side, each of the four timeout codes is tried in turn. The bench also holds the trigger high, lets it fall, changes the select code without a restart, and asserts a reset while the interrupt is set. These cases separate edge detection from level detection, a latched select from a live one, and a sticky interrupt from one that clears by itself.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    RG_HOLD    = 2'd0,
    RG_STRETCH = 2'd1,
    RG_RUN     = 2'd2
  } rg_state_e;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sup_timebase.sv
module sup_timebase #(
  parameter int TICK_DIV = 32,
  parameter int MS_TICKS = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ms_o
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int MW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;

  logic [DW-1:0] div_q;
  logic [MW-1:0] tk_q;
  logic          tick;

  assign tick = (div_q == DW'(TICK_DIV - 1));
  assign ms_o = tick && (tk_q == MW'(MS_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      tk_q  <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) tk_q <= (tk_q == MW'(MS_TICKS - 1)) ? '0 : tk_q + 1'b1;
    end
  end

  generate
    if (TICK_DIV > 1) begin : g_ms_chk
      p_ms_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ms_o |=> !ms_o);
    end
  endgenerate
endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen
  import sup_pkg::*;
#(
  parameter int N_RAILS    = 6,
  parameter int STRETCH_MS = 200
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_RAILS-1:0] rail_ok_i,
  input  logic               mr_ni,
  input  logic               stretch_en_i,
  input  logic               ms_i,
  output logic               rst_no_o
);
  localparam int SW = $clog2(STRETCH_MS + 1);

  rg_state_e     st_q, st_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic          fault;

  assign fault = !(&rail_ok_i) || !mr_ni;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      RG_HOLD: if (!fault) begin
        cnt_d = '0;
        st_d  = stretch_en_i ? RG_STRETCH : RG_RUN;
      end
      RG_STRETCH: begin
        if (fault)              st_d = RG_HOLD;
        else if (!stretch_en_i) st_d = RG_RUN;
        else if (ms_i) begin
          if (cnt_q == SW'(STRETCH_MS - 1)) st_d = RG_RUN;
          else                              cnt_d = cnt_q + 1'b1;
        end
      end
      RG_RUN: if (fault) st_d = RG_HOLD;
      default: st_d = RG_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RG_HOLD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign rst_no_o = (st_q == RG_RUN);

  p_fault_asserts_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> !rst_no_o);
  p_fast_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault && !stretch_en_i) |=> rst_no_o);
  p_stretch_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RG_STRETCH) |-> (cnt_q < SW'(STRETCH_MS)));
  p_stretch_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rst_no_o) && $past(stretch_en_i)) |-> ($past(cnt_q) == SW'(STRETCH_MS - 1)));
endmodule

// File: rtl/sup_wdt.sv
module sup_wdt #(
  parameter int WDT_MS_0 = 500,
  parameter int WDT_MS_1 = 2000,
  parameter int WDT_MS_2 = 10000,
  parameter int WDT_MS_3 = 60000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kick_i,
  input  logic [1:0] sel_i,
  input  logic       hold_i,
  input  logic       ms_i,
  output logic       irq_o
);
  localparam int M01 = (WDT_MS_0 > WDT_MS_1) ? WDT_MS_0 : WDT_MS_1;
  localparam int M23 = (WDT_MS_2 > WDT_MS_3) ? WDT_MS_2 : WDT_MS_3;
  localparam int LIM_MAX = (M01 > M23) ? M01 : M23;
  localparam int CW = $clog2(LIM_MAX + 1);

  function automatic logic [CW-1:0] lim_of(input logic [1:0] s);
    case (s)
      2'd0:    return CW'(WDT_MS_0);
      2'd1:    return CW'(WDT_MS_1);
      2'd2:    return CW'(WDT_MS_2);
      default: return CW'(WDT_MS_3);
    endcase
  endfunction

  logic          kick_d, kick_edge, irq_q;
  logic [CW-1:0] cnt_q, lim_q;

  assign kick_edge = kick_i && !kick_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kick_d <= 1'b0;
      irq_q  <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= CW'(WDT_MS_0);
    end else begin
      kick_d <= kick_i;
      if (hold_i || kick_edge) begin
        irq_q <= 1'b0;
        cnt_q <= '0;
        lim_q <= lim_of(sel_i);
      end else if (ms_i && !irq_q) begin
        if (cnt_q == lim_q - 1'b1) irq_q <= 1'b1;
        else                       cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign irq_o = irq_q;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < lim_q);
  p_kick_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_edge |=> !irq_o);
  p_irq_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !kick_edge && !hold_i) |=> irq_o);
  p_hold_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (!irq_o && cnt_q == '0));
  p_lim_latched_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !kick_edge) |=> $stable(lim_q));
endmodule

// File: rtl/sup_rst_wdt.sv
module sup_rst_wdt #(
  parameter int N_RAILS    = 6,
  parameter int TICK_DIV   = 32,
  parameter int MS_TICKS   = 250,
  parameter int STRETCH_MS = 200,
  parameter int WDT_MS_0   = 500,
  parameter int WDT_MS_1   = 2000,
  parameter int WDT_MS_2   = 10000,
  parameter int WDT_MS_3   = 60000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_RAILS-1:0] rail_ok_i,
  input  logic               mr_ni,
  input  logic               wdt_kick_i,
  input  logic               stretch_sel_i,
  input  logic [1:0]         wdt_sel_i,
  output logic               cpu_rst_no,
  output logic               wdt_irq_o
);
  localparam int SYW = N_RAILS + 5;

  logic [SYW-1:0] sy_d, sy_q;
  logic           ms;

  assign sy_d = {wdt_sel_i, stretch_sel_i, wdt_kick_i, mr_ni, rail_ok_i};

  sup_sync #(.W(SYW), .RST_VAL('0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sy_d),
    .q_o   (sy_q)
  );

  sup_timebase #(.TICK_DIV(TICK_DIV), .MS_TICKS(MS_TICKS)) u_tb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ms_o  (ms)
  );

  sup_rst_gen #(.N_RAILS(N_RAILS), .STRETCH_MS(STRETCH_MS)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rail_ok_i   (sy_q[N_RAILS-1:0]),
    .mr_ni       (sy_q[N_RAILS]),
    .stretch_en_i(sy_q[N_RAILS+2]),
    .ms_i        (ms),
    .rst_no_o    (cpu_rst_no)
  );

  sup_wdt #(
    .WDT_MS_0(WDT_MS_0), .WDT_MS_1(WDT_MS_1),
    .WDT_MS_2(WDT_MS_2), .WDT_MS_3(WDT_MS_3)
  ) u_wdt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .kick_i(sy_q[N_RAILS+1]),
    .sel_i (sy_q[SYW-1:SYW-2]),
    .hold_i(!cpu_rst_no),
    .ms_i  (ms),
    .irq_o (wdt_irq_o)
  );
endmodule

// File: tb/sup_rst_wdt_test.sv
module sup_rst_wdt_test;
  localparam int NR     = 6;
  localparam int CPM    = 2;  // master clocks per ms with TICK_DIV=2, MS_TICKS=1
  localparam int ST_MS  = 200;
  localparam int WD_LIM = 195000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] rails = '1;
  logic          mr_n = 1'b1;
  logic          kick = 1'b0;
  logic          stretch = 1'b0;
  logic [1:0]    sel = 2'd0;
  logic          cpu_rst_n, irq;

  always #10 clk = ~clk;

  sup_rst_wdt #(.N_RAILS(NR), .TICK_DIV(2), .MS_TICKS(1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rail_ok_i(rails), .mr_ni(mr_n),
    .wdt_kick_i(kick), .stretch_sel_i(stretch), .wdt_sel_i(sel),
    .cpu_rst_no(cpu_rst_n), .wdt_irq_o(irq)
  );

  typedef struct { int cyc; int r; int i; string req; } exp_t;
  exp_t q[$];
  exp_t it;
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  function automatic int wdt_ms(int s);
    case (s)
      0: return 500;
      1: return 2000;
      2: return 10000;
      default: return 60000;
    endcase
  endfunction

  // driver side: expected value at a future sampling point (-1 = don't care)
  task automatic expect_at(int dly, int r, int i, string req);
    exp_t e;
    e.cyc = cyc + dly; e.r = r; e.i = i; e.req = req;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic kick_pulse();
    kick = 1'b1; step(3); kick = 1'b0;
  endtask

  // monitor: samples on the falling edge
  always @(negedge clk) begin
    cyc++;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      checks++;
      if ((it.r >= 0 && cpu_rst_n !== it.r[0]) || (it.i >= 0 && irq !== it.i[0])) begin
        fails++;
        $display("FAIL %s cyc=%0d: rst_n=%0b irq=%0b expected rst_n=%0d irq=%0d",
                 it.req, cyc, cpu_rst_n, irq, it.r, it.i);
      end
    end
  end

  initial begin
    step(1);
    expect_at(2, 0, 0, "R10 reset state");
    step(5);
    rst_n = 1'b1;
    expect_at(8, 1, 0, "R2 release after reset");
    step(10);

    // R4: each rail alone
    for (int k = 0; k < NR; k++) begin
      rails[k] = 1'b0;
      expect_at(6, 0, 0, "R4 rail fault");
      step(8);
      rails[k] = 1'b1;
      expect_at(6, 1, -1, "R2 immediate release");
      step(8);
    end
    // R1: manual reset
    mr_n = 1'b0;
    expect_at(6, 0, 0, "R1 manual reset");
    expect_at(40, 0, 0, "R1 manual reset held");
    step(42);
    mr_n = 1'b1;
    expect_at(6, 1, -1, "R2 release after manual");
    step(8);

    // R3: stretched release and restart on fault during stretch
    stretch = 1'b1;
    rails[0] = 1'b0; step(6); rails[0] = 1'b1;
    expect_at(5, 0, 0, "R3 stretch begins");
    expect_at(ST_MS*CPM - 10, 0, 0, "R3 still stretched");
    expect_at(ST_MS*CPM + 12, 1, -1, "R3 stretch ends");
    step(ST_MS*CPM + 20);
    rails[1] = 1'b0; step(6); rails[1] = 1'b1;
    step(ST_MS*CPM / 2);
    mr_n = 1'b0; step(4); mr_n = 1'b1;
    expect_at(ST_MS*CPM - 10, 0, 0, "R3 stretch restarted");
    expect_at(ST_MS*CPM + 12, 1, -1, "R3 restarted stretch ends");
    step(ST_MS*CPM + 20);
    stretch = 1'b0;
    step(4);

    // R5 and R7: each timeout code
    for (int s = 0; s < 4; s++) begin
      sel = s[1:0];
      step(4);
      expect_at(8, 1, 0, "R6 kick clears");
      expect_at(wdt_ms(s)*CPM - 6, 1, 0, "R5 not yet expired");
      expect_at(wdt_ms(s)*CPM + 8, 1, 1, "R5 expired");
      expect_at(wdt_ms(s)*CPM + 60, 1, 1, "R7 irq sticky");
      kick_pulse();
      step(wdt_ms(s)*CPM + 62);
    end

    // R6: level held high is not a restart
    sel = 2'd0; step(4);
    kick = 1'b1;
    expect_at(8, 1, 0, "R6 edge clears");
    expect_at(500*CPM - 6, 1, 0, "R6 counting");
    expect_at(500*CPM + 8, 1, 1, "R6 level ignored");
    step(500*CPM + 10);
    kick = 1'b0;
    expect_at(10, 1, 1, "R6 falling edge ignored");
    step(12);

    // R9: select change applies at next restart only
    kick_pulse();
    step(100);
    sel = 2'd3;
    expect_at(500*CPM - 6 - 103, 1, 0, "R9 old limit running");
    expect_at(500*CPM + 8 - 103, 1, 1, "R9 old limit kept");
    step(500*CPM + 10 - 103);
    expect_at(8, 1, 0, "R9 kick clears");
    expect_at(500*CPM + 20, 1, 0, "R9 new limit used");
    kick_pulse();
    step(500*CPM + 22);

    // R8: reset clears irq and restarts the count at release
    sel = 2'd0; step(4);
    kick_pulse();
    step(500*CPM + 10);
    expect_at(1, 1, 1, "R8 irq set before reset");
    step(2);
    rails[2] = 1'b0;
    expect_at(6, 0, 0, "R8 irq cleared by reset");
    expect_at(30, 0, 0, "R8 held during reset");
    step(32);
    rails[2] = 1'b1;
    expect_at(500*CPM - 10, 1, 0, "R8 count restarted");
    expect_at(500*CPM + 12, 1, 1, "R8 expires after release");
    step(500*CPM + 14);

    wait (q.size() == 0);
    step(2);
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WD_LIM) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung at cyc=%0d expected completion", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule